// File: doc/BRIEF.md
# SPI Byte Shift Engine

This block is the serial core of an SPI master. It accepts 8-bit words from a transmit byte stream and shifts each one out MSB first on the serial data output. At the same time it shifts in a byte from the serial data input and hands that byte to a receive stream. Clock polarity and clock phase are configuration inputs, so all four standard SPI modes are available. A 16-bit divider sets the serial clock rate from the core clock. Each byte takes nine serial clock periods: eight data clocks, then one idle clock.

Shifting happens only while the run-enable input is high. While it is low, the engine stays idle, accepts no byte and drives every chip-select line inactive. A two-bit select field picks one of three chip-select lines; the value 3 drives none of them. For three-wire use, a read-enable input releases the data line and samples the pad instead of the separate input line. FIFOs, interrupts and word packing sit outside the block. It connects to them through valid/ready byte handshakes and pauses at byte boundaries whenever the transmit side is empty or the receive side is full.

Top module: `spi_byte_engine`

## Requirements
- R1: Each half period of the serial clock lasts D/2 core clocks. D is the divider value with bit 0 cleared, a value of 1 counts as 2, and a value of 0 counts as 65536. The first leading edge comes D/2 core clocks after the byte is accepted.
- R2: A byte gives exactly 8 serial clock pulses. When bytes run back to back, the first leading edges of consecutive bytes are 9 serial periods (9*D core clocks) apart.
- R3: Data is MSB first in both directions. In phase 0 the engine samples the input on the leading edge and changes its output on the trailing edge.
- R4: Between bytes and while idle, the serial clock rests at the level of the polarity input (0 or 1).
- R5: In phase 1 the engine changes its output on the leading edge and samples the input on the trailing edge.
- R6: While run-enable is low, transmit ready is low, busy is low, no serial clock edges occur and all chip selects are inactive. Dropping run-enable in the middle of a byte aborts that byte at once.
- R7: While run-enable is high, chip-select line n is driven to the chip-select polarity level when the select field equals n (0, 1 or 2). Every other line is at the opposite level. Select value 3 drives no line active.
- R8: When read-enable is high, the data output enable is low and received bits come from the data pad input, not from the separate serial input.
- R9: A new byte starts only at a byte boundary, and only if a transmit byte is offered and the receive slot is empty or being drained. Otherwise the engine goes idle with the serial clock at its rest level and gives no extra pulses.
- R10: A received byte is presented with receive valid high. Valid and data hold steady until the consumer takes the byte with receive ready.
- R11: Busy rises on the clock edge after a transmit byte is accepted and stays high until the byte's idle period ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_div_i | input | 16 | Serial clock divider (even, 0 means 65536) |
| cpol_i | input | 1 | Serial clock rest level |
| cpha_i | input | 1 | Clock phase: 0 samples on leading edge, 1 on trailing edge |
| cs_pol_i | input | 1 | Active level of the chip-select lines |
| rd_en_i | input | 1 | Three-wire read: release data line and sample the pad |
| active_i | input | 1 | Run enable for shifting and chip select |
| cs_sel_i | input | 2 | Chip-select line index, 3 selects none |
| tx_data_i | input | 8 | Transmit byte |
| tx_valid_i | input | 1 | Transmit byte offered |
| tx_ready_o | output | 1 | Engine takes a transmit byte this cycle |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Received byte available |
| rx_ready_i | input | 1 | Consumer takes the received byte |
| sclk_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data output |
| sdo_oe_o | output | 1 | Output enable for the serial data line |
| sdo_i | input | 1 | Data pad input, used in three-wire read |
| sdi_i | input | 1 | Serial data input |
| cs_o | output | 3 | Chip-select lines |
| busy_o | output | 1 | A byte is being shifted |

## Verification
The bound checker checks on every cycle the rules that depend on the current state alone or on the previous cycle. These are: the clock rest level when not busy, the gating of ready and chip selects by run-enable, at most one active chip select, the released data line in three-wire read, busy after an accepted byte, and a held receive byte. Other behaviour only shows when whole bytes are driven through a bench slave model. That covers the MSB-first data in each phase mode, the measured half-period for even, odd, one and zero divider values, the nine-period byte spacing, the stall when the receive slot is full, and the abort partway through a byte.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SHIFT = 1'b1
  } eng_state_e;
endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] half_d, half_q, cnt_q;

  // even divider: drop bit 0, 1 acts as 2, 0 acts as 2**DIV_W
  always_comb begin
    if (div_i == '0)                    half_d = {1'b1, {(DIV_W-1){1'b0}}};
    else if (div_i[DIV_W-1:1] == '0)    half_d = DIV_W'(1);
    else                                half_d = {1'b0, div_i[DIV_W-1:1]};
  end

  assign tick_o = run_i && (cnt_q == half_q - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= DIV_W'(1);
      cnt_q  <= '0;
    end else if (load_i) begin
      half_q <= half_d;
      cnt_q  <= '0;
    end else if (!run_i || tick_o) begin
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/spi_bit_phase.sv
module spi_bit_phase #(
  parameter int BITS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic load_i,
  input  logic tick_i,
  output logic lead_o,
  output logic first_lead_o,
  output logic trail_o,
  output logic last_data_o,
  output logic end_o,
  output logic sclk_act_o
);
  localparam int DATA_PH = 2 * BITS;
  localparam int PH_N    = DATA_PH + 2;
  localparam int PH_W    = $clog2(PH_N);

  logic [PH_W-1:0] ph_q;
  logic            in_data;

  assign in_data      = ph_q < PH_W'(DATA_PH);
  assign lead_o       = tick_i && !ph_q[0] && in_data;
  assign first_lead_o = tick_i && (ph_q == '0);
  assign trail_o      = tick_i && ph_q[0] && in_data;
  assign last_data_o  = tick_i && (ph_q == PH_W'(DATA_PH - 1));
  assign end_o        = tick_i && (ph_q == PH_W'(PH_N - 1));
  assign sclk_act_o   = run_i && ph_q[0] && in_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ph_q <= '0;
    else if (load_i || !run_i)   ph_q <= '0;
    else if (tick_i)             ph_q <= end_o ? '0 : ph_q + PH_W'(1);
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [BITS-1:0] tx_byte_i,
  input  logic            shift_i,
  input  logic            sample_i,
  input  logic            din_i,
  input  logic            push_i,
  input  logic            rx_ready_i,
  output logic            sdo_o,
  output logic [BITS-1:0] rx_data_o,
  output logic            rx_valid_o
);
  logic [BITS-1:0] tx_sr_q, rx_sr_q, rx_next;

  assign rx_next = {rx_sr_q[BITS-2:0], din_i};
  assign sdo_o   = tx_sr_q[BITS-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tx_sr_q <= '0;
    else if (load_i)   tx_sr_q <= tx_byte_i;
    else if (shift_i)  tx_sr_q <= {tx_sr_q[BITS-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rx_sr_q <= '0;
    else if (sample_i)  rx_sr_q <= rx_next;
  end

  // one-byte output slot; the top only starts a byte when it will be free
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
    end else if (push_i) begin
      rx_data_o  <= sample_i ? rx_next : rx_sr_q;
      rx_valid_o <= 1'b1;
    end else if (rx_valid_o && rx_ready_i) begin
      rx_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_cs_decode.sv
module spi_cs_decode #(
  parameter int CS_N  = 3,
  parameter int SEL_W = 2
) (
  input  logic             active_i,
  input  logic             cs_pol_i,
  input  logic [SEL_W-1:0] cs_sel_i,
  output logic [CS_N-1:0]  cs_o
);
  for (genvar g = 0; g < CS_N; g++) begin : g_cs
    assign cs_o[g] = (active_i && (cs_sel_i == SEL_W'(g))) ? cs_pol_i : ~cs_pol_i;
  end
endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
  parameter int DIV_W = 16,
  parameter int BITS  = 8,
  parameter int CS_N  = 3,
  parameter int SEL_W = $clog2(CS_N + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] clk_div_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic             cs_pol_i,
  input  logic             rd_en_i,
  input  logic             active_i,
  input  logic [SEL_W-1:0] cs_sel_i,
  input  logic [BITS-1:0]  tx_data_i,
  input  logic             tx_valid_i,
  output logic             tx_ready_o,
  output logic [BITS-1:0]  rx_data_o,
  output logic             rx_valid_o,
  input  logic             rx_ready_i,
  output logic             sclk_o,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  input  logic             sdo_i,
  input  logic             sdi_i,
  output logic [CS_N-1:0]  cs_o,
  output logic             busy_o
);
  import spi_eng_pkg::*;

  eng_state_e state_q, state_d;
  logic run, tick, lead, first_lead, trail, last_data, byte_end, sclk_act;
  logic rx_free, slot_open, load, shift_en, sample_en, din;

  assign run       = (state_q == ST_SHIFT);
  assign rx_free   = !rx_valid_o || rx_ready_i;
  assign slot_open = active_i && rx_free && (!run || byte_end);
  assign load      = slot_open && tx_valid_i;
  assign tx_ready_o = slot_open;

  always_comb begin
    state_d = state_q;
    if (!active_i)      state_d = ST_IDLE;
    else if (load)      state_d = ST_SHIFT;
    else if (byte_end)  state_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // same clock waveform for both phases; only the shift/sample edge swaps
  assign shift_en  = cpha_i ? (lead && !first_lead) : trail;
  assign sample_en = cpha_i ? trail : lead;
  assign din       = rd_en_i ? sdo_i : sdi_i;

  spi_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .load_i (load),
    .div_i  (clk_div_i),
    .tick_o (tick)
  );

  spi_bit_phase #(.BITS(BITS)) u_phase (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run),
    .load_i       (load),
    .tick_i       (tick),
    .lead_o       (lead),
    .first_lead_o (first_lead),
    .trail_o      (trail),
    .last_data_o  (last_data),
    .end_o        (byte_end),
    .sclk_act_o   (sclk_act)
  );

  spi_shifter #(.BITS(BITS)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .tx_byte_i  (tx_data_i),
    .shift_i    (shift_en),
    .sample_i   (sample_en),
    .din_i      (din),
    .push_i     (last_data),
    .rx_ready_i (rx_ready_i),
    .sdo_o      (sdo_o),
    .rx_data_o  (rx_data_o),
    .rx_valid_o (rx_valid_o)
  );

  spi_cs_decode #(.CS_N(CS_N), .SEL_W(SEL_W)) u_cs (
    .active_i (active_i),
    .cs_pol_i (cs_pol_i),
    .cs_sel_i (cs_sel_i),
    .cs_o     (cs_o)
  );

  assign sclk_o   = cpol_i ^ sclk_act;
  assign sdo_oe_o = !rd_en_i;
  assign busy_o   = run;
endmodule

// File: rtl/spi_byte_engine_chk.sv
module spi_byte_engine_chk #(
  parameter int BITS  = 8,
  parameter int CS_N  = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cpol_i,
  input logic            cs_pol_i,
  input logic            rd_en_i,
  input logic            active_i,
  input logic            tx_valid_i,
  input logic            tx_ready_o,
  input logic [BITS-1:0] rx_data_o,
  input logic            rx_valid_o,
  input logic            rx_ready_i,
  input logic            sclk_o,
  input logic            sdo_oe_o,
  input logic [CS_N-1:0] cs_o,
  input logic            busy_o
);
  assert_rest_level_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> sclk_o == cpol_i);

  assert_gate_ready_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |-> !tx_ready_o && (cs_o == {CS_N{~cs_pol_i}}));

  assert_cs_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(cs_o ^ {CS_N{~cs_pol_i}}) <= 1);

  assert_line_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |-> !sdo_oe_o);

  assert_rx_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o && !rx_ready_i |=> rx_valid_o && $stable(rx_data_o));

  assert_busy_after_accept_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_i && tx_ready_o |=> busy_o);
endmodule

bind spi_byte_engine spi_byte_engine_chk #(.BITS(BITS), .CS_N(CS_N)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cpol_i     (cpol_i),
  .cs_pol_i   (cs_pol_i),
  .rd_en_i    (rd_en_i),
  .active_i   (active_i),
  .tx_valid_i (tx_valid_i),
  .tx_ready_o (tx_ready_o),
  .rx_data_o  (rx_data_o),
  .rx_valid_o (rx_valid_o),
  .rx_ready_i (rx_ready_i),
  .sclk_o     (sclk_o),
  .sdo_oe_o   (sdo_oe_o),
  .cs_o       (cs_o),
  .busy_o     (busy_o)
);

// File: tb/sim_spi_byte_engine.sv
module sim_spi_byte_engine;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] clk_div = 16'd4;
  logic cpol = 1'b0, cpha = 1'b0, cs_pol = 1'b0, rd_en = 1'b0, active = 1'b0;
  logic [1:0] cs_sel = 2'd0;
  logic [7:0] tx_data = 8'h00;
  logic tx_valid = 1'b0, rx_ready = 1'b1;
  logic tx_ready, rx_valid, sclk, sdo, sdo_oe, busy;
  logic [7:0] rx_data;
  logic [2:0] cs;
  logic sdo_pad, sdi;

  // slave model state
  logic [7:0] s_byte = 8'h00;
  logic [2:0] kk = 3'd0;
  logic mbit = 1'b0, inv_sdi = 1'b0, inv_pad = 1'b1, sclk_prev = 1'b0;
  logic [7:0] capsr = 8'h00;
  int capbits = 0, cap_n = 0, ln = 0, rx_n = 0, cyc = 0, acc_cyc = 0;
  int lt [32];
  logic [7:0] cap [8];
  logic [7:0] rxv [8];
  int n_chk = 0, n_fail = 0;

  assign sdi     = mbit ^ inv_sdi;
  assign sdo_pad = mbit ^ inv_pad;

  spi_byte_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .clk_div_i(clk_div), .cpol_i(cpol), .cpha_i(cpha),
    .cs_pol_i(cs_pol), .rd_en_i(rd_en), .active_i(active), .cs_sel_i(cs_sel),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready),
    .sclk_o(sclk), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .sdo_i(sdo_pad), .sdi_i(sdi),
    .cs_o(cs), .busy_o(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // slave model and monitors, evaluated at the falling edge
  always @(negedge clk) begin
    logic lead_e, trail_e;
    lead_e  = (sclk_prev == cpol) && (sclk != cpol);
    trail_e = (sclk_prev != cpol) && (sclk == cpol);
    if (lead_e) begin
      if (ln < 32) lt[ln] = cyc;
      ln = ln + 1;
    end
    if (cpha ? trail_e : lead_e) begin
      capsr = {capsr[6:0], sdo};
      capbits = capbits + 1;
      if (capbits == 8) begin
        if (cap_n < 8) cap[cap_n] = capsr;
        cap_n = cap_n + 1;
        capbits = 0;
      end
    end
    if (!cpha && trail_e) begin
      kk = kk + 3'd1;
      mbit = s_byte[3'd7 - kk];
    end
    if (cpha && lead_e) begin
      mbit = s_byte[3'd7 - kk];
      kk = kk + 3'd1;
    end
    if (rx_valid && rx_ready) begin
      if (rx_n < 8) rxv[rx_n] = rx_data;
      rx_n = rx_n + 1;
    end
    sclk_prev = sclk;
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_model(input logic [7:0] sb);
    repeat (3) step();
    s_byte = sb; kk = 3'd0; mbit = sb[7];
    capbits = 0; cap_n = 0; ln = 0; rx_n = 0;
    sclk_prev = sclk;
  endtask

  task automatic push(input logic [7:0] b);
    int guard = 0;
    tx_data = b; tx_valid = 1'b1;
    while (!tx_ready && guard < 5000) begin step(); guard++; end
    acc_cyc = cyc + 1;
    step();
    tx_valid = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    step();
    while ((busy || tx_valid) && guard < 100000) begin step(); guard++; end
    repeat (4) step();
  endtask

  task automatic t_reset();
    chk("R11 busy after reset", busy, 0);
    chk("R4 rest level after reset", sclk, 0);
    chk("R10 rx empty after reset", rx_valid, 0);
    chk("R6 cs idle after reset", cs, 3'b111);
  endtask

  task automatic t_inactive();
    bit rdy_seen = 0;
    clr_model(8'h00);
    tx_data = 8'h33; tx_valid = 1'b1;
    repeat (20) begin step(); if (tx_ready) rdy_seen = 1; end
    chk("R6 no ready when inactive", rdy_seen, 0);
    chk("R6 not busy when inactive", busy, 0);
    chk("R6 no clocks when inactive", ln, 0);
    tx_valid = 1'b0;
    step();
  endtask

  task automatic t_mode0();
    active = 1'b1; cs_sel = 2'd0; clk_div = 16'd4; cpol = 0; cpha = 0;
    clr_model(8'h3C);
    chk("R7 select line 0", cs, 3'b110);
    push(8'hA5);
    repeat (2) step();
    chk("R11 busy during byte", busy, 1);
    wait_idle();
    chk("R3 mode0 sent byte", cap[0], 8'hA5);
    chk("R3 mode0 received byte", rxv[0], 8'h3C);
    chk("R1 div4 first edge delay", lt[0] - acc_cyc, 2);
    chk("R1 div4 period", lt[1] - lt[0], 4);
    chk("R11 busy cleared after byte", busy, 0);
    // back to back
    clr_model(8'hE7);
    push(8'h81);
    push(8'h7E);
    wait_idle();
    chk("R2 pulses for two bytes", ln, 16);
    chk("R2 byte spacing 9 periods", lt[8] - lt[0], 36);
    chk("R3 second byte sent", cap[1], 8'h7E);
    chk("R3 second byte received", rxv[1], 8'hE7);
    chk("R4 rest level mode0", sclk, 0);
  endtask

  task automatic t_mode3();
    cpol = 1; cpha = 1; clk_div = 16'd5;
    clr_model(8'h5B);
    chk("R4 rest level high", sclk, 1);
    push(8'hE4);
    wait_idle();
    chk("R5 mode3 sent byte", cap[0], 8'hE4);
    chk("R5 mode3 received byte", rxv[0], 8'h5B);
    chk("R1 odd divider rounds down", lt[1] - lt[0], 4);
    chk("R1 odd divider first edge", lt[0] - acc_cyc, 2);
    chk("R2 pulses one byte", ln, 8);
    chk("R4 rest after mode3 byte", sclk, 1);
    cpol = 0; cpha = 1;
    clr_model(8'h2D);
    push(8'h96);
    wait_idle();
    chk("R5 mode1 sent byte", cap[0], 8'h96);
    chk("R5 mode1 received byte", rxv[0], 8'h2D);
    cpha = 0;
  endtask

  task automatic t_div_edge();
    clk_div = 16'd1;
    clr_model(8'hF0);
    push(8'h0F);
    wait_idle();
    chk("R1 divider one acts as two", lt[1] - lt[0], 2);
    chk("R3 fast byte sent", cap[0], 8'h0F);
    chk("R3 fast byte received", rxv[0], 8'hF0);
    clk_div = 16'd0;
    clr_model(8'h00);
    push(8'hFF);
    begin
      int guard = 0;
      while (ln < 1 && guard < 40000) begin step(); guard++; end
    end
    chk("R1 divider zero half period", lt[0] - acc_cyc, 32768);
    active = 1'b0;
    step();
    chk("R6 abort clears busy", busy, 0);
    chk("R6 abort rest level", sclk, 0);
    chk("R6 abort cs idle", cs, 3'b111);
    chk("R10 abort pushes no byte", rx_valid, 0);
    active = 1'b1;
    clk_div = 16'd2;
  endtask

  task automatic t_cs();
    cs_sel = 2'd3;
    step();
    chk("R7 select 3 none active", cs, 3'b111);
    cs_pol = 1'b1; cs_sel = 2'd2;
    step();
    chk("R7 high polarity line 2", cs, 3'b100);
    active = 1'b0;
    step();
    chk("R6 high polarity inactive", cs, 3'b000);
    active = 1'b1; cs_pol = 1'b0; cs_sel = 2'd0;
  endtask

  task automatic t_three_wire();
    bit oe_seen = 0;
    rd_en = 1'b1; inv_sdi = 1'b1; inv_pad = 1'b0;
    clr_model(8'h96);
    push(8'h00);
    repeat (6) begin step(); if (sdo_oe) oe_seen = 1; end
    wait_idle();
    chk("R8 line released", oe_seen, 0);
    chk("R8 pad sampled", rxv[0], 8'h96);
    rd_en = 1'b0; inv_sdi = 1'b0; inv_pad = 1'b1;
    step();
    chk("R8 line driven after read", sdo_oe, 1);
  endtask

  task automatic t_stall();
    clk_div = 16'd2;
    clr_model(8'hC3);
    rx_ready = 1'b0;
    push(8'h5A);
    tx_data = 8'h11; tx_valid = 1'b1;
    repeat (60) step();
    chk("R10 rx valid held", rx_valid, 1);
    chk("R10 rx data held", rx_data, 8'hC3);
    chk("R9 stalled not busy", busy, 0);
    chk("R9 stalled rest level", sclk, 0);
    chk("R9 stalled no ready", tx_ready, 0);
    chk("R9 stalled no extra pulses", ln, 8);
    rx_ready = 1'b1;
    begin
      int guard = 0;
      while (!tx_ready && guard < 100) begin step(); guard++; end
    end
    step();
    tx_valid = 1'b0;
    wait_idle();
    chk("R9 resumed byte sent", cap[1], 8'h11);
    chk("R9 both bytes delivered", rx_n, 2);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_inactive();
    t_mode0();
    t_mode3();
    t_div_edge();
    t_cs();
    t_three_wire();
    t_stall();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule